// File: doc/BRIEF.md
# Peripheral Bus Clock Divider

This block derives a peripheral bus clock from a faster input clock. It does not make a second clock. It produces a clock-enable pulse train on `clk_en_o`: one pulse every N input cycles, where N is the programmed divide field plus one. Peripherals on the slow bus use the pulse as a clock qualifier. A gate bit in the control word stops the pulses without stopping the internal count.

Software reaches the block through a small write port and a read word. There are four addresses:
- a direct write to the control word;
- a set alias, which only sets the bits that are 1 in the data;
- a clear alias, which only clears the bits that are 1 in the data;
- a key register.

A change of the divide field is protected in three ways. It is accepted only right after a two-word key sequence. It is accepted only while the ready flag is high. Once accepted, it is held pending until the running output period finishes. Ready stays low from the accepted write until the new ratio is in force.

There is no data stream, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `pbclk_div`

## Requirements
- R1: After reset the read word is 0x8801: gate bit 15 = 1, ready bit 11 = 1, divide field bits 6:0 = 1 (ratio 2). All other bits read 0.
- R2: With the gate on, `clk_en_o` is high for one cycle in every (field+1) cycles. Field 0 gives a pulse every cycle, and field 127 gives a period of 128.
- R3: With gate bit 15 at 0, `clk_en_o` stays low. Setting the bit again restores the pulses. The gate bit can be written without the key sequence.
- R4: Address 0 replaces the control bits. Address 1 sets only the bits that are 1 in the data. Address 2 clears only the bits that are 1 in the data. Bit 11 and the reserved bits are read-only, so writing them has no effect.
- R5: A write of 0xA5C3 and then 0x3C5A to address 3, with no other write in between, opens the lock for exactly one following write to addresses 0 to 2. A divide change while the lock is closed is ignored.
- R6: An accepted divide write drops ready for at least 2 cycles, even when the value is unchanged. Ready rises again once the new ratio is loaded, and the field then reads back the written value.
- R7: A new ratio takes effect only at the end of the output period that is running when the write is accepted. That period completes with the old length.
- R8: A divide write made while ready is low is ignored, even if the lock is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_addr_i | input | 2 | 0 control, 1 set alias, 2 clear alias, 3 key |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Control/status word: gate 15, ready 11, divide field 6:0 |
| clk_en_o | output | 1 | Divided clock-enable pulse |

## Verification
The pulse period is measured at field values 0, 4, 7, 127 and at values built through the set and clear aliases. These cases separate an off-by-one in the ratio from a wrong saturation at either end.

The timing of a divide write is tested in three ways:
- A same-value rewrite at ratio 1 shows that ready stays low for at least two cycles even when nothing changes.
- A write landing just after a pulse shows whether the old period completes before the new one starts.
- A second write during a long pending period shows that writes made while busy are dropped.

Lock tests use a correct key pair, a broken pair, and reuse of a consumed unlock. They show whether the lock is single-shot and depends on the order of the key words.

// File: rtl/pbdiv_pkg.sv
package pbdiv_pkg;

  // Write port address decode.
  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_SET  = 2'd1,
    ADR_CLR  = 2'd2,
    ADR_KEY  = 2'd3
  } pbdiv_addr_e;

  // Key sequence tracker states.
  typedef enum logic [1:0] {
    KL_IDLE = 2'd0,
    KL_HALF = 2'd1,
    KL_OPEN = 2'd2
  } keylock_e;

endpackage

// File: rtl/pbdiv_keylock.sv
module pbdiv_keylock
  import pbdiv_pkg::*;
#(
  parameter int unsigned     DATA_W     = 16,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 16'hA5C3,
  parameter logic [DATA_W-1:0] KEY_SECOND = 16'h3C5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              unlocked
);

  keylock_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= KL_IDLE;
    end else if (wr_en) begin
      if (wr_addr == ADR_KEY) begin
        if (state_q == KL_HALF && wr_data == KEY_SECOND)
          state_q <= KL_OPEN;
        else if (wr_data == KEY_FIRST)
          state_q <= KL_HALF;
        else
          state_q <= KL_IDLE;
      end else begin
        // Any control write consumes an open lock (single shot).
        state_q <= KL_IDLE;
      end
    end
  end

  assign unlocked = (state_q == KL_OPEN);

  // R5: the lock only opens right after the second key word.
  p_open_after_key2_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(wr_en && wr_addr == ADR_KEY && wr_data == KEY_SECOND));

  // R5: a control write always closes the lock.
  p_single_shot_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != ADR_KEY) |=> !unlocked);

endmodule

// File: rtl/pbdiv_ctrlreg.sv
module pbdiv_ctrlreg
  import pbdiv_pkg::*;
#(
  parameter int unsigned DIV_W    = 7,
  parameter int unsigned RST_DIV  = 1,
  parameter bit          RST_EN   = 1'b1,
  parameter int unsigned MIN_HOLD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DIV_W-1:0] wr_div,
  input  logic             wr_gate,
  input  logic             unlocked,
  input  logic             load_ack,
  output logic [DIV_W-1:0] div_prog,
  output logic             gate_en,
  output logic             ready,
  output logic             load_req
);

  localparam int unsigned AGE_W = (MIN_HOLD < 2) ? 1 : $clog2(MIN_HOLD + 1);
  localparam logic [AGE_W-1:0] AGE_TOP = AGE_W'(MIN_HOLD - 1);

  logic             is_ctrl;
  logic             div_touch;
  logic [DIV_W-1:0] nx_div;
  logic             nx_gate;
  logic             accept;
  logic             pending_q;
  logic [AGE_W-1:0] age_q;

  assign is_ctrl = wr_en && (wr_addr != ADR_KEY);

  // Next value of the writable fields for each alias.
  always_comb begin
    nx_div    = div_prog;
    nx_gate   = gate_en;
    div_touch = 1'b0;
    case (wr_addr)
      ADR_CTRL: begin
        nx_div    = wr_div;
        nx_gate   = wr_gate;
        div_touch = 1'b1;
      end
      ADR_SET: begin
        nx_div    = div_prog | wr_div;
        nx_gate   = gate_en | wr_gate;
        div_touch = |wr_div;
      end
      ADR_CLR: begin
        nx_div    = div_prog & ~wr_div;
        nx_gate   = gate_en & ~wr_gate;
        div_touch = |wr_div;
      end
      default: begin
        nx_div    = div_prog;
        nx_gate   = gate_en;
        div_touch = 1'b0;
      end
    endcase
  end

  assign accept = is_ctrl && div_touch && unlocked && !pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_en   <= RST_EN;
      div_prog  <= DIV_W'(RST_DIV);
      pending_q <= 1'b0;
      age_q     <= '0;
    end else begin
      if (is_ctrl) gate_en <= nx_gate;
      if (accept) begin
        div_prog  <= nx_div;
        pending_q <= 1'b1;
        age_q     <= '0;
      end else if (pending_q) begin
        if (load_ack)
          pending_q <= 1'b0;
        else if (age_q < AGE_TOP)
          age_q <= age_q + 1'b1;
      end
    end
  end

  assign ready    = !pending_q;
  assign load_req = pending_q && (age_q >= AGE_TOP);

  // R8: a control write while busy leaves the divide field alone.
  p_busy_ignored_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (is_ctrl && pending_q) |=> $stable(div_prog));

  // R5: without the key sequence the divide field is frozen.
  p_locked_ignored_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (is_ctrl && !unlocked) |=> $stable(div_prog));

  // R7: the counter only acknowledges a pending load.
  p_ack_needs_pending_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    load_ack |-> pending_q);

  // R6: ready returns once the load is done.
  p_ready_after_load_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    load_ack |=> ready);

  generate
    if (MIN_HOLD >= 2) begin : g_hold_chk
      // R6: ready stays low for at least two cycles.
      p_ready_min_low_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |=> !ready);
    end
  endgenerate

endmodule

// File: rtl/pbdiv_counter.sv
module pbdiv_counter #(
  parameter int unsigned DIV_W   = 7,
  parameter int unsigned RST_DIV = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_req,
  input  logic [DIV_W-1:0] new_div,
  output logic             wrap,
  output logic             load_ack
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_act_q;

  assign wrap     = (cnt_q == div_act_q);
  assign load_ack = load_req && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      div_act_q <= DIV_W'(RST_DIV);
    end else if (wrap) begin
      cnt_q <= '0;
      if (load_req) div_act_q <= new_div;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2: the count never passes the active terminal value.
  p_cnt_in_range_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_act_q);

  // R7: a load restarts the period with the new ratio.
  p_load_restart_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    load_ack |=> (cnt_q == '0 && div_act_q == $past(new_div)));

endmodule

// File: rtl/pbclk_div.sv
module pbclk_div #(
  parameter int unsigned       DIV_W      = 7,
  parameter int unsigned       DATA_W     = 16,
  parameter int unsigned       GATE_POS   = 15,
  parameter int unsigned       RDY_POS    = 11,
  parameter int unsigned       RST_DIV    = 1,
  parameter bit                RST_EN     = 1'b1,
  parameter int unsigned       MIN_HOLD   = 2,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 16'hA5C3,
  parameter logic [DATA_W-1:0] KEY_SECOND = 16'h3C5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              clk_en_o
);

  logic             unlocked;
  logic [DIV_W-1:0] div_prog;
  logic             gate_en;
  logic             ready;
  logic             load_req;
  logic             load_ack;
  logic             wrap;

  pbdiv_keylock #(
    .DATA_W    (DATA_W),
    .KEY_FIRST (KEY_FIRST),
    .KEY_SECOND(KEY_SECOND)
  ) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .wr_data (wr_data_i),
    .unlocked(unlocked)
  );

  pbdiv_ctrlreg #(
    .DIV_W   (DIV_W),
    .RST_DIV (RST_DIV),
    .RST_EN  (RST_EN),
    .MIN_HOLD(MIN_HOLD)
  ) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .wr_div  (wr_data_i[DIV_W-1:0]),
    .wr_gate (wr_data_i[GATE_POS]),
    .unlocked(unlocked),
    .load_ack(load_ack),
    .div_prog(div_prog),
    .gate_en (gate_en),
    .ready   (ready),
    .load_req(load_req)
  );

  pbdiv_counter #(
    .DIV_W  (DIV_W),
    .RST_DIV(RST_DIV)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_req(load_req),
    .new_div (div_prog),
    .wrap    (wrap),
    .load_ack(load_ack)
  );

  always_comb begin
    rd_data_o              = '0;
    rd_data_o[DIV_W-1:0]   = div_prog;
    rd_data_o[RDY_POS]     = ready;
    rd_data_o[GATE_POS]    = gate_en;
  end

  assign clk_en_o = wrap & gate_en;

endmodule

// File: tb/test_pbclk_div.sv
module test_pbclk_div;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = 2'd0;
  logic [15:0] wr_data_i = 16'h0;
  logic [15:0] rd_data_o;
  logic        clk_en_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  pbclk_div i_pbclk_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o),
    .clk_en_o (clk_en_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      n_checks = n_checks + 1;
      n_fail   = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks = n_checks + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // All tasks are entered at a falling edge and return at one.
  task automatic do_write(input logic [1:0] a, input logic [15:0] d);
    wr_en_i   = 1'b1;
    wr_addr_i = a;
    wr_data_i = d;
    @(negedge clk);
    wr_en_i   = 1'b0;
  endtask

  task automatic unlock();
    do_write(2'd3, 16'hA5C3);
    do_write(2'd3, 16'h3C5A);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 400; i++) begin
      if (rd_data_o[11]) break;
      @(negedge clk);
    end
  endtask

  task automatic measure(output int p);
    for (int i = 0; i < 300; i++) begin
      if (clk_en_o) break;
      @(negedge clk);
    end
    p = 0;
    do begin
      @(negedge clk);
      p++;
    end while (!clk_en_o && p < 300);
  endtask

  task automatic set_div(input int v);
    unlock();
    do_write(2'd0, 16'h8000 | 16'(v));
    wait_ready();
  endtask

  task automatic t_reset();
    int p;
    chk("R1 reset word", rd_data_o, 16'h8801);
    measure(p);
    chk("R2 reset period", p, 2);
  endtask

  task automatic t_periods();
    int p;
    set_div(0);
    chk("R6 readback 0", rd_data_o, 16'h8800);
    measure(p);
    chk("R2 period field 0", p, 1);
    set_div(4);
    measure(p);
    chk("R2 period field 4", p, 5);
    set_div(127);
    chk("R6 readback 127", rd_data_o, 16'h887F);
    measure(p);
    chk("R2 period field 127", p, 128);
  endtask

  task automatic t_gate();
    int seen;
    int p;
    set_div(2);
    do_write(2'd2, 16'h8000);
    chk("R3 gate bit cleared", rd_data_o, 16'h0802);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      if (clk_en_o) seen++;
      @(negedge clk);
    end
    chk("R3 no pulses when gated", seen, 0);
    do_write(2'd1, 16'h8000);
    chk("R3 gate bit set", rd_data_o, 16'h8802);
    measure(p);
    chk("R3 pulses restored", p, 3);
  endtask

  task automatic t_alias();
    int p;
    set_div(4);
    unlock();
    do_write(2'd1, 16'h0003);
    wait_ready();
    chk("R4 set alias", rd_data_o, 16'h8807);
    measure(p);
    chk("R4 period after set", p, 8);
    unlock();
    do_write(2'd2, 16'h0005);
    wait_ready();
    chk("R4 clear alias", rd_data_o, 16'h8802);
    do_write(2'd1, 16'h0800);
    chk("R4 ready bit read-only", rd_data_o, 16'h8802);
    do_write(2'd0, 16'h8802 | 16'h7780);
    chk("R4 reserved bits read-only", rd_data_o, 16'h8802);
  endtask

  task automatic t_lock();
    do_write(2'd0, 16'h8009);
    chk("R5 locked write ignored", rd_data_o, 16'h8802);
    do_write(2'd3, 16'hA5C3);
    do_write(2'd3, 16'h1234);
    do_write(2'd0, 16'h8009);
    chk("R5 broken key ignored", rd_data_o, 16'h8802);
    do_write(2'd3, 16'h3C5A);
    do_write(2'd3, 16'hA5C3);
    do_write(2'd0, 16'h8009);
    chk("R5 reversed key ignored", rd_data_o, 16'h8802);
    unlock();
    do_write(2'd0, 16'h8009);
    wait_ready();
    chk("R5 unlocked write taken", rd_data_o, 16'h8809);
    do_write(2'd0, 16'h8003);
    chk("R5 unlock is single shot", rd_data_o, 16'h8809);
  endtask

  task automatic t_hold();
    set_div(0);
    unlock();
    do_write(2'd0, 16'h8000);
    chk("R6 ready low cycle 1", rd_data_o[11], 0);
    @(negedge clk);
    chk("R6 ready low cycle 2", rd_data_o[11], 0);
    @(negedge clk);
    chk("R6 ready back", rd_data_o[11], 1);
    chk("R6 readback same value", rd_data_o, 16'h8800);
  endtask

  task automatic t_boundary();
    int g;
    int p;
    set_div(7);
    unlock();
    for (int i = 0; i < 20; i++) begin
      if (clk_en_o) break;
      @(negedge clk);
    end
    do_write(2'd0, 16'h8002);
    chk("R6 ready low after write", rd_data_o[11], 0);
    g = 1;
    while (!clk_en_o && g < 300) begin
      @(negedge clk);
      g++;
    end
    chk("R7 old period completes", g, 8);
    measure(p);
    chk("R7 new period", p, 3);
    chk("R7 ready after load", rd_data_o, 16'h8802);
  endtask

  task automatic t_busy();
    int p;
    set_div(127);
    unlock();
    do_write(2'd0, 16'h8010);
    unlock();
    do_write(2'd0, 16'h8020);
    chk("R8 busy write ignored", rd_data_o, 16'h0810 ^ 16'h0800 | 16'h8000);
    wait_ready();
    chk("R8 first value kept", rd_data_o, 16'h8810);
    measure(p);
    chk("R8 period of first value", p, 17);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_periods();
    t_gate();
    t_alias();
    t_lock();
    t_hold();
    t_boundary();
    t_busy();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule